// File: doc/BRIEF.md
# Mode-Selectable Bitstream Output Stage

This block sits behind a single-bit oversampling converter and decides how its raw bitstream leaves the chip. Two mode pins pick the clock that times the stream and the form the data pin takes. The clock is either a free-running on-chip oscillator or a clock brought in from outside. The data is either the plain captured bit or a self-clocking split-phase symbol.

In the plain modes the bitstream is retimed on the rising edge of the chosen clock, and that clock is driven out beside it. A receiver then samples the data on the falling edge. In the split-phase mode the clock pin is parked low and every bit period carries one mid-period transition, so the receiver recovers timing from the data line alone. The oscillator and the converter are modelled as plain inputs. A separate output tells the oscillator when it is needed.

Top module: `bitstream_out_stage`

## Requirements
- R1: `mode_sel[1]` is the upper mode pin and `mode_sel[0]` the lower one. Mode 3 (`2'b11`) selects `ext_clk` as the timing clock, and every other mode selects `osc_clk`. `osc_en` is low in mode 3 and high in modes 0, 1 and 2.
- R2: `mod_bit` is captured on the rising edge of the selected clock. `dat_out` depends only on that captured bit and the selected clock, never directly on `mod_bit`.
- R3: In modes 0 (`2'b00`) and 1 (`2'b01`), `dat_out` equals the captured bit for the whole period, and `clk_out` follows `osc_clk`.
- R4: In mode 2 (`2'b10`), `dat_out` equals the captured bit while the selected clock is high and its inverse while the clock is low. A 1 is therefore sent high-then-low and a 0 low-then-high.
- R5: In mode 2, `clk_out` is held at a constant low level.
- R6: In mode 3, `dat_out` equals the captured bit and does not change at the falling edge of `ext_clk`, and `clk_out` follows `ext_clk`.
- R7: While `rst_n` is low, the captured bit is forced to 0 asynchronously, so `dat_out` is 0 in modes 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | On-chip oscillator clock |
| ext_clk | input | 1 | Clock supplied from outside |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode pins: bit 1 upper, bit 0 lower |
| mod_bit | input | 1 | Raw single-bit converter stream |
| osc_en | output | 1 | Oscillator enable, low in mode 3 |
| clk_out | output | 1 | Forwarded clock, or low in mode 2 |
| dat_out | output | 1 | Retimed bit or split-phase symbol |

## Verification
The hardest case to reach is proving that the two halves of a split-phase symbol come from one captured bit. The source bit must change between the capture edge and the mid-period edge, and the output must not follow it. The bench presents the bit at the falling edge, holds it across the capture edge, and reads the pin in both halves. Each mode is swept over every 4-bit pattern, which covers each run, each alternation and each bit change. In mode 3 the two clocks run at unrelated periods, so a design that timed its data from the oscillator would fall out of step and show wrong values.

// File: rtl/bitstream_out_stage.sv
module bitstream_out_stage #(
  parameter bit RESET_BIT = 1'b0
) (
  input  logic       osc_clk,
  input  logic       ext_clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       mod_bit,
  output logic       osc_en,
  output logic       clk_out,
  output logic       dat_out
);
  logic use_ext, split_phase, sel_clk, bit_q;

  assign use_ext     = (mode_sel == 2'b11);
  assign split_phase = (mode_sel == 2'b10);
  assign osc_en      = ~use_ext;
  assign sel_clk     = use_ext ? ext_clk : osc_clk;

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) bit_q <= RESET_BIT;
    else        bit_q <= mod_bit;
  end

  assign clk_out = split_phase ? 1'b0 : sel_clk;
  assign dat_out = split_phase ? (bit_q ~^ sel_clk) : bit_q;
endmodule

// File: rtl/bitstream_out_stage_chk.sv
module bitstream_out_stage_chk (
  input logic       osc_clk,
  input logic       ext_clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       mod_bit,
  input logic       osc_en,
  input logic       clk_out,
  input logic       dat_out
);
  logic       cap_o, ok_o, cap_e, ok_e;
  logic [1:0] mode_o, mode_e;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o <= 1'b0; ok_o <= 1'b0; mode_o <= 2'b00;
    end else begin
      cap_o <= mod_bit; ok_o <= 1'b1; mode_o <= mode_sel;
    end
  end

  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_e <= 1'b0; ok_e <= 1'b0; mode_e <= 2'b00;
    end else begin
      cap_e <= mod_bit; ok_e <= 1'b1; mode_e <= mode_sel;
    end
  end

  AST_SPLIT_CLK_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> (clk_out == 1'b0)); // R5

  AST_EXT_OSC_OFF: assert property (@(posedge ext_clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (osc_en == 1'b0)); // R1

  AST_EXT_RAW_HOLD: assert property (@(negedge ext_clk) disable iff (!rst_n)
    (ok_e && mode_e == 2'b11 && mode_sel == 2'b11) |-> (dat_out == cap_e && clk_out)); // R6

  AST_SPLIT_FIRST_HALF: assert property (@(negedge osc_clk) disable iff (!rst_n)
    (ok_o && mode_o == 2'b10 && mode_sel == 2'b10) |-> (dat_out == cap_o)); // R4

  AST_PLAIN_OSC: assert property (@(negedge osc_clk) disable iff (!rst_n)
    (ok_o && !mode_o[1] && !mode_sel[1]) |-> (dat_out == cap_o && clk_out && osc_en)); // R3
endmodule

bind bitstream_out_stage bitstream_out_stage_chk u_chk (
  .osc_clk(osc_clk), .ext_clk(ext_clk), .rst_n(rst_n), .mode_sel(mode_sel),
  .mod_bit(mod_bit), .osc_en(osc_en), .clk_out(clk_out), .dat_out(dat_out)
);

// File: tb/bitstream_out_stage_test.sv
module bitstream_out_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_PERIOD = 14;

  logic       osc_clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0, mod_bit = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       osc_en, clk_out, dat_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  bitstream_out_stage uut (
    .osc_clk(osc_clk), .ext_clk(ext_clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .mod_bit(mod_bit), .osc_en(osc_en), .clk_out(clk_out), .dat_out(dat_out)
  );

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(EXT_PERIOD/2) ext_clk = ~ext_clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_rise(input logic [1:0] m);
    if (m == 2'b11) @(posedge ext_clk); else @(posedge osc_clk);
  endtask

  task automatic wait_fall(input logic [1:0] m);
    if (m == 2'b11) @(negedge ext_clk); else @(negedge osc_clk);
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      logic [1:0] md;
      md = m[1:0];
      rst_n = 1'b0;
      mode_sel = md;
      mod_bit = 1'b1;
      repeat (3) @(posedge osc_clk);
      #1;
      check("R1", "osc_en", osc_en, (md != 2'b11));
      if (md != 2'b10) check("R7", "dat_out in reset", dat_out, 1'b0);
      wait_fall(md);
      #1;
      rst_n = 1'b1;
      for (int p = 0; p < 16; p++) begin
        for (int k = 3; k >= 0; k--) begin
          logic b;
          b = p[k];
          mod_bit = b;
          wait_rise(md);
          #1;
          mod_bit = ~b;
          case (md)
            2'b10: begin
              check("R4", "first half", dat_out, b);
              check("R5", "clk_out high phase", clk_out, 1'b0);
            end
            2'b11: begin
              check("R6", "dat first half", dat_out, b);
              check("R6", "clk_out high", clk_out, 1'b1);
            end
            default: begin
              check("R3", "dat first half", dat_out, b);
              check("R3", "clk_out high", clk_out, 1'b1);
            end
          endcase
          wait_fall(md);
          #1;
          case (md)
            2'b10: begin
              check("R4", "second half", dat_out, ~b);
              check("R5", "clk_out low phase", clk_out, 1'b0);
            end
            2'b11: begin
              check("R6", "dat after fall", dat_out, b);
              check("R6", "clk_out low", clk_out, 1'b0);
            end
            default: begin
              check("R2", "dat after fall", dat_out, b);
              check("R3", "clk_out low", clk_out, 1'b0);
            end
          endcase
          check("R1", "osc_en", osc_en, (md != 2'b11));
        end
      end
      mod_bit = 1'b1;
      wait_rise(md);
      #1;
      rst_n = 1'b0;
      #1;
      if (md != 2'b10) check("R7", "async clear", dat_out, 1'b0);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule